// File: doc/BRIEF.md
# Exception Prioritizer and Vector Generator

This block sits beside the completion stage of a simple in-order core. Each cycle it gathers every exception condition the core can raise and arbitrates among them. The arbitration works by class. Non-maskable asynchronous events come first, then precise synchronous events raised by the completing instruction, then maskable asynchronous requests. The block then issues one vector offset together with a one-cycle take strobe. Maskable asynchronous requests are held in pending flags until they are both enabled and the winner. A machine check that arrives while machine checks are disabled does not produce a vector; it drives the block into a sticky halted state instead.

The surrounding core saves its own state, flushes its own pipeline and fetches from the offset. This block only decides what is taken and when. Synchronous conditions that lose arbitration in their cycle are dropped, because the core re-executes the instruction after the handler returns.

Top module: `exc_prio_vec`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after release, `take_exc` is 0, `vec_off` is 0 and `checkstop` is 0. A reset pulse also clears `checkstop`.
- R2: Outputs are registered. A synchronous or non-maskable condition presented before a clock edge appears on `take_exc`/`vec_off` after that edge. A maskable asynchronous condition is first latched at one edge and issued at the next. In any cycle without a taken exception, `vec_off` is 0 and `take_exc` is 0.
- R3: `sys_rst_req` issues 0x00100 and `mchk_req` with `mchk_en`=1 issues 0x00200. Both beat every other source, and the reset request beats the machine check.
- R4: `mchk_req` with `mchk_en`=0 sets `checkstop` after the edge. No vector is issued in that cycle, and none is issued afterwards, until `rst_n` is pulsed.
- R5: Synchronous vectors, highest first: program error 0x00700, then floating-point unavailable 0x00800 (`fp_instr`=1 with `st_fp`=0), then system call 0x00C00, then instruction breakpoint 0x01300, then trace 0x00D00. Synchronous conditions that lose arbitration in the same cycle are discarded.
- R6: Trace fires when `insn_done`=1 and either `st_se`=1, or `insn_branch`=1 with `st_be`=1. It never fires while `insn_isync`=1.
- R7: The breakpoint fires when `insn_done`=1, `bkpt_en`=1, `bkpt_te` equals `st_ir`, and the word addresses `bkpt_addr` and `next_ea` are equal. These two ports carry address bits EA_W-1 down to 2.
- R8: Any synchronous exception beats a pending maskable request. That request stays pending and is issued in a later cycle.
- R9: A 0-to-1 change of `dec_top` latches a decrementer request whatever `st_ee` is, and the request is issued as 0x00900 once `st_ee`=1. A high `dec_top` at reset release is not an edge, and one edge gives one vector.
- R10: `sysmgmt_req_n` low latches a system-management request, which is issued as 0x01400 only while `st_ee`=1.
- R11: `therm_over` with `therm_en`=1 latches a thermal request, issued as 0x01700 only while `st_ee`=1. `perf_limit` latches a performance-monitor request, issued as 0x00F00 while `perf_int_en`=1, independent of `st_ee`.
- R12: Among enabled pending requests, system management wins, then decrementer, then performance monitor, then thermal. A pending flag clears in the cycle its vector is issued, so each latched request yields exactly one vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| sys_rst_req | input | 1 | System reset exception request |
| mchk_req | input | 1 | Machine-check condition |
| mchk_en | input | 1 | Machine checks enabled (else checkstop) |
| prog_err | input | 1 | Program-error strobe from completing instruction |
| fp_instr | input | 1 | Completing instruction is floating-point |
| st_fp | input | 1 | Floating-point available state bit |
| sc_instr | input | 1 | System-call strobe |
| insn_done | input | 1 | An instruction completes this cycle |
| insn_branch | input | 1 | Completing instruction is a branch |
| insn_isync | input | 1 | Completing instruction is an instruction-synchronize |
| st_se | input | 1 | Single-step trace enable |
| st_be | input | 1 | Branch trace enable |
| st_ee | input | 1 | External/asynchronous interrupt enable |
| st_ir | input | 1 | Instruction translation enable |
| dec_top | input | 1 | Most significant bit of the decrementer |
| sysmgmt_req_n | input | 1 | Active-low system-management request pin |
| perf_limit | input | 1 | Performance counter reached its limit |
| perf_int_en | input | 1 | Performance-monitor interrupt enable |
| therm_en | input | 1 | Thermal management enabled |
| therm_over | input | 1 | Temperature above threshold |
| bkpt_addr | input | EA_W-2 | Breakpoint word address |
| bkpt_te | input | 1 | Breakpoint translation-enable match value |
| bkpt_en | input | 1 | Breakpoint enable |
| next_ea | input | EA_W-2 | Word address of the completing instruction |
| take_exc | output | 1 | One-cycle take strobe |
| vec_off | output | VEC_W | Vector offset of the taken exception, 0 if none |
| checkstop | output | 1 | Sticky halted state |

## Verification
The bench targets collisions between classes. The first is a pending system-management request meeting a program error: a design that ranked classes wrongly would issue 0x01400 first, or would drop the request after it lost. The second is an instruction-synchronize completing under single-step, where a careless trace term would raise 0x00D00. The third is a decrementer edge seen with interrupts disabled: a design that gated the edge rather than the delivery would never issue 0x00900. Further runs hold a disabled machine check, which must stay silent even when a reset request follows, and drain four pending requests in a row, where a flag that failed to clear would issue the same vector twice.

// File: rtl/exc_prio_vec.sv
`timescale 1ns/1ps
module exc_prio_vec #(
  parameter int EA_W  = 32,
  parameter int VEC_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_rst_req,
  input  logic              mchk_req,
  input  logic              mchk_en,
  input  logic              prog_err,
  input  logic              fp_instr,
  input  logic              st_fp,
  input  logic              sc_instr,
  input  logic              insn_done,
  input  logic              insn_branch,
  input  logic              insn_isync,
  input  logic              st_se,
  input  logic              st_be,
  input  logic              st_ee,
  input  logic              st_ir,
  input  logic              dec_top,
  input  logic              sysmgmt_req_n,
  input  logic              perf_limit,
  input  logic              perf_int_en,
  input  logic              therm_en,
  input  logic              therm_over,
  input  logic [EA_W-1:2]   bkpt_addr,
  input  logic              bkpt_te,
  input  logic              bkpt_en,
  input  logic [EA_W-1:2]   next_ea,
  output logic              take_exc,
  output logic [VEC_W-1:0]  vec_off,
  output logic              checkstop
);

  localparam logic [VEC_W-1:0] V_RST  = VEC_W'(20'h00100);
  localparam logic [VEC_W-1:0] V_MCHK = VEC_W'(20'h00200);
  localparam logic [VEC_W-1:0] V_PROG = VEC_W'(20'h00700);
  localparam logic [VEC_W-1:0] V_FPU  = VEC_W'(20'h00800);
  localparam logic [VEC_W-1:0] V_DEC  = VEC_W'(20'h00900);
  localparam logic [VEC_W-1:0] V_SC   = VEC_W'(20'h00C00);
  localparam logic [VEC_W-1:0] V_TRC  = VEC_W'(20'h00D00);
  localparam logic [VEC_W-1:0] V_PERF = VEC_W'(20'h00F00);
  localparam logic [VEC_W-1:0] V_BKPT = VEC_W'(20'h01300);
  localparam logic [VEC_W-1:0] V_SMGT = VEC_W'(20'h01400);
  localparam logic [VEC_W-1:0] V_THRM = VEC_W'(20'h01700);

  logic dec_q;
  logic p_smgt, p_dec, p_perf, p_thrm;
  logic c_smgt, c_dec, c_perf, c_thrm;
  logic [VEC_W-1:0] vec_nx;

  wire mchk_stop = mchk_req & ~mchk_en;
  wire halted    = checkstop | mchk_stop;

  wire fpu_hit  = fp_instr & ~st_fp;
  wire trc_hit  = insn_done & ~insn_isync & (st_se | (insn_branch & st_be));
  wire bkpt_hit = insn_done & bkpt_en & (bkpt_te == st_ir) & (bkpt_addr == next_ea);

  wire s_smgt = ~sysmgmt_req_n;
  wire s_dec  = dec_top & ~dec_q;
  wire s_perf = perf_limit;
  wire s_thrm = therm_en & therm_over;

  always_comb begin
    vec_nx = '0;
    c_smgt = 1'b0;
    c_dec  = 1'b0;
    c_perf = 1'b0;
    c_thrm = 1'b0;
    if (halted)                   vec_nx = '0;
    else if (sys_rst_req)         vec_nx = V_RST;
    else if (mchk_req)            vec_nx = V_MCHK;
    else if (prog_err)            vec_nx = V_PROG;
    else if (fpu_hit)             vec_nx = V_FPU;
    else if (sc_instr)            vec_nx = V_SC;
    else if (bkpt_hit)            vec_nx = V_BKPT;
    else if (trc_hit)             vec_nx = V_TRC;
    else if (p_smgt && st_ee)     begin vec_nx = V_SMGT; c_smgt = 1'b1; end
    else if (p_dec && st_ee)      begin vec_nx = V_DEC;  c_dec  = 1'b1; end
    else if (p_perf && perf_int_en) begin vec_nx = V_PERF; c_perf = 1'b1; end
    else if (p_thrm && st_ee)     begin vec_nx = V_THRM; c_thrm = 1'b1; end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_exc  <= 1'b0;
      vec_off   <= '0;
      checkstop <= 1'b0;
      dec_q     <= 1'b1;
      p_smgt    <= 1'b0;
      p_dec     <= 1'b0;
      p_perf    <= 1'b0;
      p_thrm    <= 1'b0;
    end else begin
      take_exc  <= (vec_nx != '0);
      vec_off   <= vec_nx;
      checkstop <= checkstop | mchk_stop;
      dec_q     <= dec_top;
      p_smgt    <= (p_smgt | s_smgt) & ~c_smgt;
      p_dec     <= (p_dec  | s_dec)  & ~c_dec;
      p_perf    <= (p_perf | s_perf) & ~c_perf;
      p_thrm    <= (p_thrm | s_thrm) & ~c_thrm;
    end
  end

  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_exc |-> vec_off == '0);

  // R2
  take_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |-> vec_off != '0);

  // R4
  checkstop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    checkstop |=> checkstop);

  // R4
  checkstop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    checkstop |-> !take_exc);

  // R3
  reset_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_req && !checkstop && !(mchk_req && !mchk_en)) |=> (take_exc && vec_off == V_RST));

  // R9
  dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p_dec && !st_ee) |=> p_dec);

  // R10
  smgt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !st_ee |=> vec_off != V_SMGT);

endmodule

// File: tb/exc_prio_vec_test.sv
`timescale 1ns/1ps
module exc_prio_vec_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sys_rst_req = 0, mchk_req = 0, mchk_en = 1, prog_err = 0, fp_instr = 0, st_fp = 1;
  logic sc_instr = 0, insn_done = 0, insn_branch = 0, insn_isync = 0, st_se = 0, st_be = 0;
  logic st_ee = 0, st_ir = 1, dec_top = 0, sysmgmt_req_n = 1, perf_limit = 0, perf_int_en = 0;
  logic therm_en = 0, therm_over = 0, bkpt_te = 1, bkpt_en = 0;
  logic [31:2] bkpt_addr = '0, next_ea = '0;
  logic take_exc, checkstop;
  logic [19:0] vec_off;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  exc_prio_vec uut (
    .clk(clk), .rst_n(rst_n), .sys_rst_req(sys_rst_req), .mchk_req(mchk_req), .mchk_en(mchk_en),
    .prog_err(prog_err), .fp_instr(fp_instr), .st_fp(st_fp), .sc_instr(sc_instr),
    .insn_done(insn_done), .insn_branch(insn_branch), .insn_isync(insn_isync),
    .st_se(st_se), .st_be(st_be), .st_ee(st_ee), .st_ir(st_ir), .dec_top(dec_top),
    .sysmgmt_req_n(sysmgmt_req_n), .perf_limit(perf_limit), .perf_int_en(perf_int_en),
    .therm_en(therm_en), .therm_over(therm_over), .bkpt_addr(bkpt_addr), .bkpt_te(bkpt_te),
    .bkpt_en(bkpt_en), .next_ea(next_ea), .take_exc(take_exc), .vec_off(vec_off),
    .checkstop(checkstop)
  );

  // {expected vector, stim}; stim bits: 11 be,10 se,9 branch,8 isync,7 done,6 sc,
  // 5 st_fp,4 fp_instr,3 prog,2 mchk_en,1 mchk,0 sys_rst
  localparam logic [31:0] TBL [15] = '{
    {20'h00700, 12'b0000_0000_1000},
    {20'h00800, 12'b0000_0001_0000},
    {20'h00000, 12'b0000_0011_0000},
    {20'h00C00, 12'b0000_0100_0000},
    {20'h00D00, 12'b0100_1000_0000},
    {20'h00D00, 12'b1010_1000_0000},
    {20'h00000, 12'b0101_1000_0000},
    {20'h00000, 12'b0010_1000_0000},
    {20'h00700, 12'b0000_0100_1000},
    {20'h00800, 12'b0000_0101_0000},
    {20'h00C00, 12'b0100_1100_0000},
    {20'h00200, 12'b0000_0000_1110},
    {20'h00100, 12'b0000_0000_0111},
    {20'h00100, 12'b0000_0000_1001},
    {20'h00000, 12'b0000_0000_0000}
  };

  task automatic chk(input string tag, input logic [19:0] exp);
    n_run++;
    if (take_exc !== (exp != 0) || vec_off !== exp) begin
      n_fail++;
      $display("FAIL %s: take=%0b vec=%h expected take=%0b vec=%h", tag, take_exc, vec_off, exp != 0, exp);
    end
  endtask

  task automatic chk_cs(input string tag, input logic exp);
    n_run++;
    if (checkstop !== exp) begin
      n_fail++;
      $display("FAIL %s: checkstop=%0b expected %0b", tag, checkstop, exp);
    end
  endtask

  task automatic drive(input logic [11:0] s);
    {st_be, st_se, insn_branch, insn_isync, insn_done, sc_instr, st_fp, fp_instr,
     prog_err, mchk_en, mchk_req, sys_rst_req} = s;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    drive(12'b0000_0010_0100);
    tick(2);
    chk("R1 reset vector", 20'h0);
    chk_cs("R1 reset checkstop", 1'b0);
    rst_n = 1'b1;
    tick(1);
    chk("R1 first cycle", 20'h0);

    for (int i = 0; i < 15; i++) begin
      drive(TBL[i][11:0]);
      tick(1);
      chk($sformatf("R3/R5/R6 table[%0d]", i), TBL[i][31:12]);
    end
    drive(12'b0000_0010_0100);
    tick(1);

    // R7 breakpoint
    next_ea = 30'h048D159E; bkpt_addr = 30'h048D159E; bkpt_en = 1; insn_done = 1;
    tick(1); chk("R7 match", 20'h01300);
    bkpt_te = 0; tick(1); chk("R7 te mismatch", 20'h0);
    bkpt_te = 1; bkpt_addr = 30'h048D159F; tick(1); chk("R7 addr mismatch", 20'h0);
    bkpt_addr = 30'h048D159E; st_se = 1; tick(1); chk("R5 bkpt over trace", 20'h01300);
    sc_instr = 1; tick(1); chk("R5 syscall over bkpt", 20'h00C00);
    sc_instr = 0; st_se = 0; insn_done = 0; bkpt_en = 0; tick(1);

    // R9 decrementer
    st_ee = 0; dec_top = 1; tick(3); chk("R9 held while disabled", 20'h0);
    st_ee = 1; tick(1); chk("R9 delivered", 20'h00900);
    tick(1); chk("R9 single vector", 20'h0);
    st_ee = 0; dec_top = 0; tick(1);

    // R10 system management
    st_ee = 1; sysmgmt_req_n = 0; tick(1); chk("R2 latch cycle", 20'h0);
    sysmgmt_req_n = 1; tick(1); chk("R10 issued", 20'h01400);
    tick(1); chk("R12 cleared after issue", 20'h0);

    // R8 sync over pending async
    st_ee = 0; sysmgmt_req_n = 0; tick(1); sysmgmt_req_n = 1; tick(2);
    chk("R10 gated by enable", 20'h0);
    st_ee = 1; prog_err = 1; tick(1); chk("R8 sync first", 20'h00700);
    prog_err = 0; tick(1); chk("R8 async later", 20'h01400);
    tick(1);

    // R12 async order
    st_ee = 0; perf_int_en = 0;
    perf_limit = 1; therm_en = 1; therm_over = 1; sysmgmt_req_n = 0; dec_top = 1;
    tick(1);
    perf_limit = 0; therm_over = 0; sysmgmt_req_n = 1;
    tick(1); chk("R12 all held", 20'h0);
    st_ee = 1; perf_int_en = 1;
    tick(1); chk("R12 order smgt", 20'h01400);
    tick(1); chk("R12 order dec", 20'h00900);
    tick(1); chk("R12 order perf", 20'h00F00);
    tick(1); chk("R11 thermal", 20'h01700);
    tick(1); chk("R12 drained", 20'h0);
    dec_top = 0;

    // R11 perf without EE, thermal disabled
    st_ee = 0; perf_limit = 1; tick(1); perf_limit = 0; tick(1);
    chk("R11 perf ignores EE", 20'h00F00);
    perf_int_en = 0; st_ee = 1; therm_en = 0; therm_over = 1; tick(3);
    chk("R11 thermal disabled", 20'h0);
    therm_over = 0; tick(1);

    // R4 checkstop
    mchk_en = 0; mchk_req = 1; tick(1);
    chk("R4 no vector", 20'h0); chk_cs("R4 entered", 1'b1);
    mchk_req = 0; prog_err = 1; sys_rst_req = 1; tick(1);
    chk("R4 silent", 20'h0); chk_cs("R4 sticky", 1'b1);
    prog_err = 0; sys_rst_req = 0; mchk_en = 1;

    // R9 high MSB at reset release, R1 clear
    dec_top = 1; st_ee = 1;
    rst_n = 0; tick(1); chk_cs("R1 reset clears checkstop", 1'b0);
    rst_n = 1; tick(3); chk("R9 no edge at reset", 20'h0);
    dec_top = 0; st_ee = 0;

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule